// File: doc/BRIEF.md
# Trace Buffer Checkpoint Unit

The unit captures one message byte per control-flow event into a power-of-two deep trace memory. Each event arrives with a type and a 32-bit target address. Two capture policies are available. In fill-once mode, capture halts once every slot holds an entry. In wrap-around mode, the newest entry overwrites the oldest one.

When a buffer has wrapped, a debugger reading it back has no starting address for the oldest entry it sees. To solve this, the unit marks selected branch entries and keeps the targets of the two most recent marked entries in a pair of 32-bit anchor registers. Marks fall about half a buffer apart. After a wrap, the older surviving marked entry therefore matches the second register and the newer one matches the first.

Software reaches the anchors through a small register port, which it can write only while capture is off. A separate read-out port walks the buffer from the oldest entry to the newest.

Top module: `trace_ckpt_unit`

## Requirements
- R1: After reset, both anchor registers read zero, the wrapped flag is low, capture is off and the write position is slot 0.
- R2: Each accepted event writes the byte {0, mark, type[1:0], info[3:0]} into the slot at the write position. The mark is bit 6. The write position then advances by one, modulo the depth. An event is accepted when capture is enabled, the event is valid and the buffer is not full in fill-once mode.
- R3: Event types are coded as direct 0, indirect 1, exception 2 and roll-over 3. Exception and roll-over entries are never marked: their bit 6 is 0 and they leave both anchors unchanged.
- R4: Marking has two boundaries, slot 0 and slot DEPTH/2. The first direct or indirect entry written at either boundary, or after it and before the next one, is marked with bit 6 set. No other entry is marked.
- R5: When an entry is marked, the second anchor takes the old value of the first anchor, and the first anchor takes the entry's target address, on the same clock edge.
- R6: The register read data shows the first anchor when the register address is 0 and the second anchor when it is 1. It is combinational and valid whether capture is on or off.
- R7: A register write with capture off loads the addressed anchor at the next edge. With capture on, register writes have no effect.
- R8: In fill-once mode, the buffer becomes full after DEPTH accepted entries. From then on, further events change neither the stored entries nor the anchors.
- R9: The wrapped flag rises on the edge that writes slot DEPTH-1. It stays high until reset. In wrap-around mode, capture then continues and overwrites from slot 0.
- R10: A read-start pulse points the read-out at the oldest entry: slot 0 if the buffer has not wrapped, otherwise the current write position. Each read-next pulse advances by one slot modulo the depth. The read byte is combinational from the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| traceEn | input | 1 | Capture enable |
| wrapMode | input | 1 | 1 selects wrap-around, 0 selects fill-once |
| evValid | input | 1 | Event present this cycle |
| evType | input | 2 | Event type code |
| evTarget | input | 32 | Event target address |
| evInfo | input | 4 | Low payload field of the message byte |
| regWrEn | input | 1 | Anchor register write strobe |
| regAddr | input | 1 | Anchor register select |
| regWrData | input | 32 | Anchor register write data |
| regRdData | output | 32 | Anchor register read data |
| rdStart | input | 1 | Point read-out at the oldest entry |
| rdNext | input | 1 | Advance read-out by one entry |
| rdByte | output | 8 | Message byte at the read position |
| wrapped | output | 1 | Buffer has wrapped or filled |

## Verification
Some properties are checked on every cycle. The anchors never move after an exception or roll-over event, or while capture is on with no event. Whenever the first anchor changes under capture, the second anchor receives its old value. A full fill-once buffer issues no memory writes, and the wrapped flag never falls. Other behaviour needs whole scenarios and a byte-level reference model. Marks must land exactly at the first eligible entry after each half-buffer boundary. The final anchor pair must match the targets of the last two marked entries. Read-out after a wrap must begin at the true oldest entry.

// File: rtl/trace_ckpt_pkg.sv
package trace_ckpt_pkg;

  localparam int INFO_W = 4;
  localparam int TGT_W  = 32;

  typedef enum logic [1:0] {
    EV_DIRECT   = 2'd0,
    EV_INDIRECT = 2'd1,
    EV_EXCEPT   = 2'd2,
    EV_ROLL     = 2'd3
  } evType_e;

  typedef struct packed {
    logic memWe;
    logic ckptTake;
    logic regWr0;
    logic regWr1;
  } ctlStrobe_t;

endpackage

// File: rtl/trace_ckpt_ctrl.sv
module trace_ckpt_ctrl
  import trace_ckpt_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       traceEn,
  input  logic                       wrapMode,
  input  logic                       evValid,
  input  logic [1:0]                 evType,
  input  logic                       regWrEn,
  input  logic                       regAddr,
  input  logic                       rdStart,
  input  logic                       rdNext,
  output ctlStrobe_t                 strobe,
  output logic [$clog2(DEPTH)-1:0]   wrIdx,
  output logic [$clog2(DEPTH)-1:0]   rdIdx,
  output logic                       wrapped
);

  localparam int PTR_W  = $clog2(DEPTH);
  localparam int HALF_W = PTR_W - 1;

  generate
    if ((1 << PTR_W) != DEPTH || DEPTH < 4) begin : g_badDepth
      $error("trace_ckpt_ctrl: DEPTH must be a power of two of at least 4");
    end
  endgenerate

  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             wrappedQ;
  logic             pending;

  logic full;
  logic accept;
  logic eligible;
  logic atBoundary;
  logic take;
  logic lastSlot;

  always_comb begin
    full       = wrappedQ & ~wrapMode;
    accept     = traceEn & evValid & ~full;
    eligible   = (evType == EV_DIRECT) || (evType == EV_INDIRECT);
    atBoundary = (wrPtr[HALF_W-1:0] == '0);
    take       = accept & eligible & (atBoundary | pending);
    lastSlot   = (wrPtr == PTR_W'(DEPTH - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      wrappedQ <= 1'b0;
      pending  <= 1'b0;
    end else if (accept) begin
      wrPtr   <= wrPtr + 1'b1;
      pending <= eligible ? 1'b0 : (atBoundary | pending);
      if (lastSlot) wrappedQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (rdStart) begin
      rdPtr <= wrappedQ ? wrPtr : '0;
    end else if (rdNext) begin
      rdPtr <= rdPtr + 1'b1;
    end
  end

  always_comb begin
    strobe.memWe    = accept;
    strobe.ckptTake = take;
    strobe.regWr0   = regWrEn & ~traceEn & ~regAddr;
    strobe.regWr1   = regWrEn & ~traceEn &  regAddr;
  end

  assign wrIdx   = wrPtr;
  assign rdIdx   = rdPtr;
  assign wrapped = wrappedQ;

endmodule

// File: rtl/trace_ckpt_dp.sv
module trace_ckpt_dp
  import trace_ckpt_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobe_t               strobe,
  input  logic [$clog2(DEPTH)-1:0] wrIdx,
  input  logic [$clog2(DEPTH)-1:0] rdIdx,
  input  logic [1:0]               evType,
  input  logic [TGT_W-1:0]         evTarget,
  input  logic [INFO_W-1:0]        evInfo,
  input  logic                     regAddr,
  input  logic [TGT_W-1:0]         regWrData,
  output logic [TGT_W-1:0]         regRdData,
  output logic [7:0]               rdByte,
  output logic [TGT_W-1:0]         ckpt0Q,
  output logic [TGT_W-1:0]         ckpt1Q
);

  logic [7:0] traceMem [DEPTH];
  logic [7:0] entryByte;

  always_comb begin
    entryByte = {1'b0, strobe.ckptTake, evType, evInfo};
  end

  always_ff @(posedge clk) begin
    if (strobe.memWe) traceMem[wrIdx] <= entryByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckpt0Q <= '0;
      ckpt1Q <= '0;
    end else if (strobe.ckptTake) begin
      ckpt1Q <= ckpt0Q;
      ckpt0Q <= evTarget;
    end else begin
      if (strobe.regWr0) ckpt0Q <= regWrData;
      if (strobe.regWr1) ckpt1Q <= regWrData;
    end
  end

  assign regRdData = regAddr ? ckpt1Q : ckpt0Q;
  assign rdByte    = traceMem[rdIdx];

endmodule

// File: rtl/trace_ckpt_unit.sv
module trace_ckpt_unit
  import trace_ckpt_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        traceEn,
  input  logic        wrapMode,
  input  logic        evValid,
  input  logic [1:0]  evType,
  input  logic [31:0] evTarget,
  input  logic [3:0]  evInfo,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        rdStart,
  input  logic        rdNext,
  output logic [7:0]  rdByte,
  output logic        wrapped
);

  localparam int PTR_W = $clog2(DEPTH);

  ctlStrobe_t       strobe;
  logic [PTR_W-1:0] wrIdx;
  logic [PTR_W-1:0] rdIdx;
  logic [31:0]      ckpt0Q;
  logic [31:0]      ckpt1Q;
  logic             memWe;

  trace_ckpt_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .traceEn  (traceEn),
    .wrapMode (wrapMode),
    .evValid  (evValid),
    .evType   (evType),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .rdStart  (rdStart),
    .rdNext   (rdNext),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .rdIdx    (rdIdx),
    .wrapped  (wrapped)
  );

  trace_ckpt_dp #(.DEPTH(DEPTH)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrIdx     (wrIdx),
    .rdIdx     (rdIdx),
    .evType    (evType),
    .evTarget  (evTarget),
    .evInfo    (evInfo),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .rdByte    (rdByte),
    .ckpt0Q    (ckpt0Q),
    .ckpt1Q    (ckpt1Q)
  );

  assign memWe = strobe.memWe;

endmodule

// File: rtl/trace_ckpt_chk.sv
module trace_ckpt_chk (
  input logic        clk,
  input logic        rstN,
  input logic        traceEn,
  input logic        wrapMode,
  input logic        evValid,
  input logic [1:0]  evType,
  input logic [31:0] ckpt0Q,
  input logic [31:0] ckpt1Q,
  input logic        wrapped,
  input logic        memWe
);

  // R5: the first anchor changing under capture hands its old value down
  a_r5_shift_order: assert property (@(posedge clk) disable iff (!rstN)
    ($past(traceEn) && (ckpt0Q != $past(ckpt0Q))) |-> (ckpt1Q == $past(ckpt0Q)));

  // R3: exception and roll-over events never move the anchors
  a_r3_no_mark_exc: assert property (@(posedge clk) disable iff (!rstN)
    (traceEn && evValid && evType[1]) |=> ($stable(ckpt0Q) && $stable(ckpt1Q)));

  // R7: with capture on and no event, nothing (including register writes) moves the anchors
  a_r7_locked: assert property (@(posedge clk) disable iff (!rstN)
    (traceEn && !evValid) |=> ($stable(ckpt0Q) && $stable(ckpt1Q)));

  // R8: a full fill-once buffer takes no writes
  a_r8_fill_stop: assert property (@(posedge clk) disable iff (!rstN)
    (wrapped && !wrapMode) |-> !memWe);

  // R9: the wrapped flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wrapped |=> wrapped);

endmodule

bind trace_ckpt_unit trace_ckpt_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .traceEn  (traceEn),
  .wrapMode (wrapMode),
  .evValid  (evValid),
  .evType   (evType),
  .ckpt0Q   (ckpt0Q),
  .ckpt1Q   (ckpt1Q),
  .wrapped  (wrapped),
  .memWe    (memWe)
);

// File: tb/test_trace_ckpt_unit.sv
module test_trace_ckpt_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        traceEn = 1'b0, wrapMode = 1'b0, evValid = 1'b0;
  logic [1:0]  evType = '0;
  logic [31:0] evTarget = '0;
  logic [3:0]  evInfo = '0;
  logic        regWrEn = 1'b0, regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        rdStart = 1'b0, rdNext = 1'b0;
  logic [7:0]  rdByte;
  logic        wrapped;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic [7:0]  mMem   [DEPTH];
  logic        mValid [DEPTH];
  int          mPtr, mRd;
  logic        mWrapped, mPend;
  logic [31:0] mC0, mC1;

  trace_ckpt_unit #(.DEPTH(DEPTH)) i_trace_ckpt_unit (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .wrapMode(wrapMode),
    .evValid(evValid), .evType(evType), .evTarget(evTarget), .evInfo(evInfo),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .rdStart(rdStart), .rdNext(rdNext),
    .rdByte(rdByte), .wrapped(wrapped)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < DEPTH; i++) mValid[i] = 1'b0;
    mPtr = 0; mRd = 0; mWrapped = 1'b0; mPend = 1'b0; mC0 = '0; mC1 = '0;
  endtask

  // compare every output against the model (model holds post-edge state)
  task automatic compareAll();
    chk("R6 regRdData", regRdData, regAddr ? mC1 : mC0);
    chk("R9 wrapped", {31'd0, wrapped}, {31'd0, mWrapped});
    if (mValid[mRd]) chk("R10 rdByte", {24'd0, rdByte}, {24'd0, mMem[mRd]});
  endtask

  task automatic modelApply();
    logic elig, bnd, take, acc;
    int   oldPtr;
    logic oldWrapped;
    oldPtr = mPtr; oldWrapped = mWrapped;
    acc = traceEn && evValid && !(mWrapped && !wrapMode);
    if (acc) begin
      elig = (evType < 2);
      bnd  = ((mPtr % (DEPTH/2)) == 0);
      take = elig && (bnd || mPend);
      mMem[mPtr]   = {1'b0, take, evType, evInfo};
      mValid[mPtr] = 1'b1;
      if (take) begin mC1 = mC0; mC0 = evTarget; end
      mPend = elig ? 1'b0 : (bnd || mPend);
      if (mPtr == DEPTH-1) mWrapped = 1'b1;
      mPtr = (mPtr + 1) % DEPTH;
    end
    if (!traceEn && regWrEn) begin
      if (regAddr) mC1 = regWrData; else mC0 = regWrData;
    end
    if (rdStart) mRd = oldWrapped ? oldPtr : 0;
    else if (rdNext) mRd = (mRd + 1) % DEPTH;
  endtask

  task automatic drive(input logic en, input logic mode, input logic v,
                       input logic [1:0] ty, input logic [31:0] tgt, input logic [3:0] inf,
                       input logic we, input logic ad, input logic [31:0] wd,
                       input logic rs, input logic rn);
    @(negedge clk);
    compareAll();
    traceEn = en; wrapMode = mode; evValid = v; evType = ty; evTarget = tgt;
    evInfo = inf; regWrEn = we; regAddr = ad; regWrData = wd; rdStart = rs; rdNext = rn;
    modelApply();
  endtask

  task automatic idle(input logic en, input logic mode, input logic ad);
    drive(en, mode, 1'b0, 2'd0, 32'd0, 4'd0, 1'b0, ad, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    traceEn = 0; evValid = 0; regWrEn = 0; rdStart = 0; rdNext = 0; regAddr = 0;
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // ---------- reset state (R1)
    doReset();
    #1;
    chk("R1 anchor0 reset", regRdData, 32'd0);
    chk("R1 wrapped reset", {31'd0, wrapped}, 32'd0);
    regAddr = 1'b1; #1;
    chk("R1 anchor1 reset", regRdData, 32'd0);
    regAddr = 1'b0;

    // ---------- fill-once scenario (R2, R3, R4, R8)
    for (int i = 0; i < 300; i++) begin
      logic [1:0] ty;
      if (i % 5 == 0)      ty = 2'd2;
      else if (i % 7 == 3) ty = 2'd3;
      else                 ty = (i % 2 == 1) ? 2'd1 : 2'd0;
      drive(1'b1, 1'b0, 1'b1, ty, 32'h1000 + i*4, 4'(i), 1'b0, 1'b0, 32'd0, 1'b0, 1'b0);
      if (i % 37 == 0) idle(1'b1, 1'b0, 1'b0);
    end
    // register write while capture is on must be ignored (R7)
    drive(1'b1, 1'b0, 1'b0, 2'd0, 32'd0, 4'd0, 1'b1, 1'b0, 32'hDEAD_BEEF, 1'b0, 1'b0);
    idle(1'b0, 1'b0, 1'b0);
    #1;
    chk("R7 write ignored while enabled", regRdData, 32'h0000_1200);
    chk("R5 anchor0 after fill", regRdData, 32'h0000_1200);
    regAddr = 1'b1; #1;
    chk("R5 anchor1 after fill", regRdData, 32'h0000_1004);
    chk("R8 full flag", {31'd0, wrapped}, 32'd1);
    regAddr = 1'b0;

    // read out from the oldest entry
    drive(1'b0, 1'b0, 1'b0, 2'd0, 32'd0, 4'd0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b0);
    idle(1'b0, 1'b0, 1'b0);
    #1;
    chk("R3 exception entry unmarked", {24'd0, rdByte}, 32'h20);
    chk("R8 slot 0 kept after full", {24'd0, rdByte}, 32'h20);
    drive(1'b0, 1'b0, 1'b0, 2'd0, 32'd0, 4'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b1);
    idle(1'b0, 1'b0, 1'b0);
    #1;
    chk("R4 first eligible entry marked", {24'd0, rdByte}, 32'h51);
    for (int k = 0; k < DEPTH; k++)
      drive(1'b0, 1'b0, 1'b0, 2'd0, 32'd0, 4'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b1);

    // register writes with capture off (R7)
    drive(1'b0, 1'b0, 1'b0, 2'd0, 32'd0, 4'd0, 1'b1, 1'b1, 32'hCAFE_0000, 1'b0, 1'b0);
    idle(1'b0, 1'b0, 1'b1);
    #1;
    chk("R7 anchor1 written while disabled", regRdData, 32'hCAFE_0000);
    drive(1'b0, 1'b0, 1'b0, 2'd0, 32'd0, 4'd0, 1'b1, 1'b0, 32'h0BAD_F00D, 1'b0, 1'b0);
    idle(1'b0, 1'b0, 1'b0);
    #1;
    chk("R7 anchor0 written while disabled", regRdData, 32'h0BAD_F00D);

    // ---------- wrap-around scenario (R9, R10, R5, R2)
    doReset();
    for (int i = 0; i < 600; i++) begin
      drive(1'b1, 1'b1, 1'b1, 2'd0, 32'(i), 4'(i), 1'b0, 1'(i % 2), 32'd0, 1'b0, 1'b0);
    end
    idle(1'b0, 1'b1, 1'b0);
    #1;
    chk("R5 anchor0 newest mark", regRdData, 32'd512);
    chk("R9 wrapped set", {31'd0, wrapped}, 32'd1);
    regAddr = 1'b1; #1;
    chk("R5 anchor1 older mark", regRdData, 32'd384);
    regAddr = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 2'd0, 32'd0, 4'd0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b0);
    idle(1'b0, 1'b1, 1'b0);
    #1;
    chk("R10 oldest after wrap", {24'd0, rdByte}, 32'h08);
    chk("R2 overwritten slot byte", {24'd0, rdByte}, 32'h08);
    for (int k = 0; k < 40; k++)
      drive(1'b0, 1'b1, 1'b0, 2'd0, 32'd0, 4'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b1);
    idle(1'b0, 1'b1, 1'b0);
    #1;
    chk("R4 half-buffer mark after wrap", {24'd0, rdByte}, 32'h40);
    for (int k = 0; k < 10; k++) idle(1'b0, 1'b1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule